// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block receives asynchronous serial frames from a single input line. It runs at 16 samples per bit, using a one-cycle baud tick that is generated elsewhere. It finds a valid start bit and shifts in 8 or 9 data positions, least significant first. When parity is on, the last data position is the parity bit. The frame ends with one stop bit. Each bit value is the majority of three samples taken near the middle of the bit. If the three samples disagree on any bit of a valid frame, the noise flag is set.

When a frame completes, a receive-full flag goes high. In that same cycle the data register, the noise flag, the framing flag and the parity flag are updated. If a frame completes while receive-full is still set, the old data and flags are kept and an overrun flag is raised.

Software reads a status word and a data word through a small read port. A flag is cleared when a status read sees it set and a data read follows.

Top module: `uart_rx_core`

## Requirements
- R1: Each bit lasts 16 baud ticks. Sample 0 of the start bit is the first tick on which the synchronized line is seen low. Each bit's value is the majority of its samples 7, 8 and 9.
- R2: A start bit whose majority value is 1 is invalid. The receiver then returns to idle, produces no frame and changes no flag.
- R3: Data positions arrive least significant first. There are 9 positions when `cfg_nine_bits` is 1 and 8 when it is 0. The data word holds them in bits 8..0. Bits 15..9 read as 0, and bit 8 reads as 0 in 8-bit mode. When parity is on, the parity bit is stored in the last position.
- R4: Noise (status bit 2) is set when the three samples of the start, any data or parity position, or the stop bit of a valid frame disagree. A low glitch on the idle line or an invalid start never sets it.
- R5: Framing error (status bit 1) is set when the stop bit's majority is 0, which includes a break (all zeros). After that, no new start is accepted until the line has been sampled high.
- R6: With `cfg_parity_en` set, parity error (status bit 0) is set when the number of ones over all data positions, parity included, is even while `cfg_parity_odd`=1, or odd while `cfg_parity_odd`=0.
- R7: The noise, framing and parity flags change only when a frame completes. They change in the same cycle that receive-full (status bit 4) rises.
- R8: If a frame completes while receive-full is set, overrun (status bit 3) is set. The data word and the other three error flags keep their old values.
- R9: A data read clears exactly the flags that were set in the most recent status read before it. A data read with no status read before it clears nothing.
- R10: When `rd_en`=1, `rd_addr`=0 selects the status word and `rd_addr`=1 selects the data word. `rd_data` shows the selected word in the next cycle. Status bits 15..5 are 0.
- R11: After reset, all flags and the data word are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| cfg_nine_bits | input | 1 | 1: 9 data positions, 0: 8 |
| cfg_parity_en | input | 1 | Last data position is parity |
| cfg_parity_odd | input | 1 | 1: odd parity, 0: even |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 1 | 0 status, 1 data |
| rd_data | output | 16 | Registered read data |

## Verification
The bench flips one sample in the start bit, in a data bit and in the stop bit. A vote taken at the wrong offset, or a noise flag limited to the data bits, would either corrupt the data or leave noise clear. It sends low glitches on the idle line, including one that covers sample 7 but not samples 8 and 9. A design that trusted the first low sample would start a frame or set noise.

It holds the line low for longer than a frame after a break; a receiver that rearms without seeing the line high would report an extra overrun. It reads status in the middle of a noisy frame, where flags that update early would show up. Finally, it lets a frame arrive between a status read and a data read. A design that clears from the live flags rather than from what the status read saw would lose the overrun.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  // status word layout, bit 4 down to bit 0
  typedef struct packed {
    logic rx_full;
    logic overrun;
    logic noise;
    logic framing;
    logic parity;
  } rx_flags_t;

  localparam int ADDR_STATUS = 0;
  localparam int ADDR_DATA   = 1;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_out
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= line_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], line_in};
      end
    end
  endgenerate

  assign line_out = chain[STAGES-1];
endmodule

// File: rtl/rx_bit_vote.sv
module rx_bit_vote #(
  parameter int OVERSAMPLE = 16,
  parameter int SAMPLE_MID = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic line,
  input  logic active,
  output logic bit_end,
  output logic bit_val,
  output logic bit_noise
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] WIN_LO = CNT_W'(SAMPLE_MID - 1);
  localparam logic [CNT_W-1:0] WIN_HI = CNT_W'(SAMPLE_MID + 1);

  logic [CNT_W-1:0] cnt;
  logic [2:0]       samp;
  logic             in_window;

  assign in_window = (cnt >= WIN_LO) && (cnt <= WIN_HI);

  // the detection tick is sample 0, so the counter waits at 1 while idle
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= CNT_W'(1);
      samp <= '1;
    end else if (tick) begin
      if (!active)           cnt <= CNT_W'(1);
      else if (cnt == LAST)  cnt <= '0;
      else                   cnt <= cnt + 1'b1;
      if (active && in_window) samp <= {samp[1:0], line};
    end
  end

  assign bit_end   = tick && active && (cnt == LAST);
  assign bit_val   = (samp[0] & samp[1]) | (samp[0] & samp[2]) | (samp[1] & samp[2]);
  assign bit_noise = !((samp == 3'b000) || (samp == 3'b111));

  // R1: a bit can only end after its three samples have been taken in this bit
  assert_end_after_window_R1: assert property (@(posedge clk) disable iff (rst)
    (tick && active && cnt == WIN_HI) |=> !bit_end);
endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import uart_rx_pkg::*;
#(
  parameter int MAX_BITS = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                line,
  input  logic                cfg_nine_bits,
  input  logic                cfg_parity_en,
  input  logic                cfg_parity_odd,
  input  logic                bit_end,
  input  logic                bit_val,
  input  logic                bit_noise,
  output logic                active,
  output logic                frame_done,
  output logic [MAX_BITS-1:0] frame_data,
  output logic                frame_noise,
  output logic                frame_ferr,
  output logic                frame_perr
);
  localparam int POS_W = $clog2(MAX_BITS);
  localparam logic [POS_W-1:0] LAST_LONG  = POS_W'(MAX_BITS - 1);
  localparam logic [POS_W-1:0] LAST_SHORT = POS_W'(MAX_BITS - 2);

  rx_state_e         state;
  logic [POS_W-1:0]  pos;
  logic [POS_W-1:0]  last_pos;
  logic [MAX_BITS-1:0] shreg;
  logic              noise_acc;
  logic              par_acc;
  logic              armed;
  logic              lat_nine, lat_par_en, lat_odd;

  assign active   = (state != ST_IDLE);
  assign last_pos = lat_nine ? LAST_LONG : LAST_SHORT;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      pos         <= '0;
      shreg       <= '0;
      noise_acc   <= 1'b0;
      par_acc     <= 1'b0;
      armed       <= 1'b0;
      lat_nine    <= 1'b0;
      lat_par_en  <= 1'b0;
      lat_odd     <= 1'b0;
      frame_done  <= 1'b0;
      frame_data  <= '0;
      frame_noise <= 1'b0;
      frame_ferr  <= 1'b0;
      frame_perr  <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (tick) begin
            if (line) begin
              armed <= 1'b1;
            end else if (armed) begin
              state      <= ST_START;
              pos        <= '0;
              shreg      <= '0;
              noise_acc  <= 1'b0;
              par_acc    <= 1'b0;
              lat_nine   <= cfg_nine_bits;
              lat_par_en <= cfg_parity_en;
              lat_odd    <= cfg_parity_odd;
            end
          end
        end
        ST_START: begin
          if (bit_end) begin
            if (bit_val) begin
              state <= ST_IDLE;
              armed <= 1'b1;
            end else begin
              state     <= ST_DATA;
              noise_acc <= bit_noise;
            end
          end
        end
        ST_DATA: begin
          if (bit_end) begin
            shreg[pos] <= bit_val;
            par_acc    <= par_acc ^ bit_val;
            noise_acc  <= noise_acc | bit_noise;
            if (pos == last_pos) state <= ST_STOP;
            else                 pos   <= pos + 1'b1;
          end
        end
        ST_STOP: begin
          if (bit_end) begin
            state       <= ST_IDLE;
            armed       <= bit_val;
            frame_done  <= 1'b1;
            frame_data  <= shreg;
            frame_noise <= noise_acc | bit_noise;
            frame_ferr  <= !bit_val;
            frame_perr  <= lat_par_en & (par_acc ^ lat_odd);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: an invalid start sends the receiver back to idle with no frame
  assert_bad_start_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START && bit_end && bit_val) |=> (state == ST_IDLE && !frame_done));

  // R5: after a break the receiver stays idle until the line is seen high
  assert_break_rearm_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !armed) |=> (state == ST_IDLE));
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int REG_W  = 16,
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              frame_noise,
  input  logic              frame_ferr,
  input  logic              frame_perr,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STATUS);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(ADDR_DATA);

  rx_flags_t         flags, flags_nxt, seen, after_clr;
  logic [DATA_W-1:0] data_q;
  logic              rd_stat, rd_dat;

  assign rd_stat = rd_en && (rd_addr == A_STAT);
  assign rd_dat  = rd_en && (rd_addr == A_DATA);

  always_comb begin
    after_clr = rd_dat ? rx_flags_t'(flags & ~seen) : flags;
    flags_nxt = after_clr;
    if (frame_done) begin
      if (after_clr.rx_full) begin
        flags_nxt.overrun = 1'b1;
      end else begin
        flags_nxt.rx_full = 1'b1;
        flags_nxt.noise   = frame_noise;
        flags_nxt.framing = frame_ferr;
        flags_nxt.parity  = frame_perr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags   <= '0;
      seen    <= '0;
      data_q  <= '0;
      rd_data <= '0;
    end else begin
      flags <= flags_nxt;
      if (frame_done && !after_clr.rx_full) data_q <= frame_data;
      if (rd_stat)     seen <= flags;
      else if (rd_dat) seen <= '0;
      if (rd_stat)     rd_data <= REG_W'(flags);
      else if (rd_dat) rd_data <= REG_W'(data_q);
    end
  end

  // R7: error flags move only on a frame completion or a clearing data read
  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!frame_done && !rd_dat) |=> $stable(flags));

  // R7: receive-full rises only with a completed frame
  assert_full_with_frame_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(flags.rx_full) |-> $past(frame_done));

  // R8: a frame landing on a full register sets overrun and keeps the data
  assert_overrun_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    (frame_done && flags.rx_full && !rd_dat) |=> (flags.overrun && $stable(data_q)));

  // R9: a data read with nothing seen by a status read clears nothing
  assert_clear_needs_status_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_dat && seen == '0 && !frame_done) |=> $stable(flags));

  // R3: upper bits of the data word read as zero
  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    rd_dat |=> (rd_data[REG_W-1:DATA_W] == '0));
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SAMPLE_MID  = 8,
  parameter int MAX_BITS    = 9,
  parameter int SYNC_STAGES = 2,
  parameter int REG_W       = 16,
  parameter int ADDR_W      = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              rxd,
  input  logic              cfg_nine_bits,
  input  logic              cfg_parity_en,
  input  logic              cfg_parity_odd,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data
);
  logic                line_s;
  logic                active, bit_end, bit_val, bit_noise;
  logic                frame_done, frame_noise, frame_ferr, frame_perr;
  logic [MAX_BITS-1:0] frame_data;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .line_in(rxd), .line_out(line_s)
  );

  rx_bit_vote #(.OVERSAMPLE(OVERSAMPLE), .SAMPLE_MID(SAMPLE_MID)) u_vote (
    .clk(clk), .rst(rst), .tick(baud_tick), .line(line_s), .active(active),
    .bit_end(bit_end), .bit_val(bit_val), .bit_noise(bit_noise)
  );

  rx_frame_ctrl #(.MAX_BITS(MAX_BITS)) u_frame (
    .clk(clk), .rst(rst), .tick(baud_tick), .line(line_s),
    .cfg_nine_bits(cfg_nine_bits), .cfg_parity_en(cfg_parity_en),
    .cfg_parity_odd(cfg_parity_odd),
    .bit_end(bit_end), .bit_val(bit_val), .bit_noise(bit_noise),
    .active(active), .frame_done(frame_done), .frame_data(frame_data),
    .frame_noise(frame_noise), .frame_ferr(frame_ferr), .frame_perr(frame_perr)
  );

  rx_status_regs #(.DATA_W(MAX_BITS), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .frame_done(frame_done), .frame_data(frame_data),
    .frame_noise(frame_noise), .frame_ferr(frame_ferr), .frame_perr(frame_perr),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: tb/test_uart_rx_core.sv
module test_uart_rx_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        baud_tick = 1'b0;
  logic        rxd = 1'b1;
  logic        cfg_nine_bits = 1'b0, cfg_parity_en = 1'b0, cfg_parity_odd = 1'b0;
  logic        rd_en = 1'b0;
  logic [0:0]  rd_addr = 1'b0;
  logic [15:0] rd_data;
  int          checks = 0, errors = 0;
  logic [1:0]  tdiv = '0;

  always #2 clk = ~clk;

  always_ff @(posedge clk) begin
    tdiv      <= tdiv + 1'b1;
    baud_tick <= (tdiv == 2'd3);
  end

  uart_rx_core i_uart_rx_core (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .rxd(rxd),
    .cfg_nine_bits(cfg_nine_bits), .cfg_parity_en(cfg_parity_en),
    .cfg_parity_odd(cfg_parity_odd), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // hold the line at v for one baud tick; that tick samples v
  task automatic slot(input logic v);
    rxd = v;
    forever begin
      @(posedge clk);
      if (baud_tick) break;
    end
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slot(1'b1);
  endtask

  task automatic rd(input logic a, output logic [15:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic clear_all();
    logic [15:0] v;
    rd(1'b0, v);
    rd(1'b1, v);
  endtask

  function automatic logic [8:0] with_par(input logic [8:0] d, input int npos, input logic odd);
    logic x = 1'b0;
    for (int i = 0; i < npos - 1; i++) x ^= d[i];
    d[npos-1] = odd ? ~x : x;
    return d;
  endfunction

  // noise_bit: -1 none, 0 start, 1..npos data positions, npos+1 stop
  task automatic send(input logic [8:0] d, input int npos, input logic stopv, input int noise_bit);
    for (int b = 0; b < npos + 2; b++) begin
      logic bv;
      bv = (b == 0) ? 1'b0 : (b == npos + 1) ? stopv : d[b-1];
      for (int s = 0; s < 16; s++) slot((b == noise_bit && s == 8) ? ~bv : bv);
    end
    if (stopv) idle(3);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(1'b0, v); chk("R11 status after reset", v, 16'h0000);
    rd(1'b1, v); chk("R11 data after reset", v, 16'h0000);
  endtask

  task automatic t_basic();
    logic [15:0] v;
    cfg_nine_bits = 0; cfg_parity_en = 0;
    send(9'h0A5, 8, 1'b1, -1);
    rd(1'b0, v); chk("R1 R10 status after 8-bit frame", v, 16'h0010);
    rd(1'b1, v); chk("R3 data 8-bit", v, 16'h00A5);
    rd(1'b0, v); chk("R9 status cleared", v, 16'h0000);
  endtask

  task automatic t_nine();
    logic [15:0] v;
    cfg_nine_bits = 1;
    send(9'h1C3, 9, 1'b1, -1);
    rd(1'b0, v); chk("R3 status 9-bit", v, 16'h0010);
    rd(1'b1, v); chk("R3 data 9-bit", v, 16'h01C3);
    cfg_nine_bits = 0;
  endtask

  task automatic t_parity();
    logic [15:0] v;
    logic [8:0]  d;
    cfg_parity_en = 1; cfg_parity_odd = 0; cfg_nine_bits = 0;
    d = with_par(9'h035, 8, 1'b0);
    send(d, 8, 1'b1, -1);
    rd(1'b0, v); chk("R6 even parity good", v, 16'h0010);
    rd(1'b1, v); chk("R3 R6 parity bit stored", v, {7'd0, d});
    d[7] = ~d[7];
    send(d, 8, 1'b1, -1);
    rd(1'b0, v); chk("R6 even parity bad", v, 16'h0011);
    rd(1'b1, v);
    cfg_nine_bits = 1; cfg_parity_odd = 1;
    d = with_par(9'h00F, 9, 1'b1);
    send(d, 9, 1'b1, -1);
    rd(1'b0, v); chk("R6 odd parity good", v, 16'h0010);
    rd(1'b1, v); chk("R6 odd parity data", v, {7'd0, d});
    d[8] = ~d[8];
    send(d, 9, 1'b1, -1);
    rd(1'b0, v); chk("R6 odd parity bad", v, 16'h0011);
    rd(1'b1, v);
    cfg_nine_bits = 0; cfg_parity_en = 0; cfg_parity_odd = 0;
  endtask

  task automatic t_noise();
    logic [15:0] v;
    send(9'h05A, 8, 1'b1, 4);
    rd(1'b0, v); chk("R4 noise on data bit", v, 16'h0014);
    rd(1'b1, v); chk("R1 majority keeps data", v, 16'h005A);
    send(9'h05A, 8, 1'b1, 0);
    rd(1'b0, v); chk("R4 noise on start bit", v, 16'h0014);
    rd(1'b1, v);
    send(9'h05A, 8, 1'b1, 9);
    rd(1'b0, v); chk("R4 noise on stop bit", v, 16'h0014);
    rd(1'b1, v); chk("R1 data with stop noise", v, 16'h005A);
  endtask

  task automatic t_glitch();
    logic [15:0] v;
    slot(1'b0); idle(30);
    rd(1'b0, v); chk("R2 R4 one-sample idle glitch", v, 16'h0000);
    for (int i = 0; i < 8; i++) slot(1'b0);
    idle(30);
    rd(1'b0, v); chk("R2 R4 invalid start, sample 7 low", v, 16'h0000);
    send(9'h03C, 8, 1'b1, -1);
    rd(1'b0, v); chk("R2 clean frame after glitches", v, 16'h0010);
    rd(1'b1, v); chk("R2 data after glitches", v, 16'h003C);
  endtask

  task automatic t_break();
    logic [15:0] v;
    send(9'h000, 8, 1'b0, -1);
    for (int i = 0; i < 200; i++) slot(1'b0);
    idle(20);
    rd(1'b0, v); chk("R5 break sets framing, no rearm while low", v, 16'h0012);
    rd(1'b1, v); chk("R5 break data", v, 16'h0000);
  endtask

  task automatic t_overrun();
    logic [15:0] v;
    send(9'h011, 8, 1'b1, -1);
    send(9'h022, 8, 1'b1, 3);
    rd(1'b0, v); chk("R8 overrun keeps old flags", v, 16'h0018);
    rd(1'b1, v); chk("R8 overrun keeps old data", v, 16'h0011);
    rd(1'b0, v); chk("R9 overrun cleared", v, 16'h0000);
  endtask

  task automatic t_partial();
    logic [15:0] v;
    send(9'h033, 8, 1'b1, -1);
    rd(1'b0, v); chk("R9 status before late frame", v, 16'h0010);
    send(9'h044, 8, 1'b1, -1);
    rd(1'b1, v); chk("R8 data from first frame", v, 16'h0033);
    rd(1'b0, v); chk("R9 unseen overrun survives", v, 16'h0008);
    rd(1'b1, v);
    rd(1'b0, v); chk("R9 overrun cleared on second pass", v, 16'h0000);
  endtask

  task automatic t_no_status();
    logic [15:0] v;
    send(9'h055, 8, 1'b1, -1);
    rd(1'b1, v); chk("R10 data read", v, 16'h0055);
    rd(1'b0, v); chk("R9 data read alone clears nothing", v, 16'h0010);
    rd(1'b1, v);
  endtask

  task automatic t_midframe();
    logic [15:0] v;
    fork
      send(9'h066, 8, 1'b1, 0);
      begin
        repeat (400) @(posedge clk);
        rd(1'b0, v); chk("R7 no flag mid-frame", v, 16'h0000);
      end
    join
    rd(1'b0, v); chk("R7 flags with full at frame end", v, 16'h0014);
    rd(1'b1, v);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    idle(4);
    t_reset();
    t_basic();
    t_nine();
    t_parity();
    t_noise();
    t_glitch();
    t_break();
    t_overrun();
    t_partial();
    t_no_status();
    t_midframe();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule